// File: doc/BRIEF.md
# Hierarchical Interrupt Flag Controller

This block collects event pulses from up to six peripheral modules, each with sixteen interrupt sources, and turns them into one interrupt request for a processor that has a single interrupt vector. Every source owns a sticky flag that records its event whatever the enables say. The request comes from three levels of enable in series: a per-source enable, a per-module enable and one global enable. Software selects the ordering of service. It reads a top identification register to see which modules hold an enabled pending source. It then reads that module's 16-bit identification register to find the function that raised it. Last, it clears the flag with a write-one-to-clear access.

Each source is built either as an asynchronous input or as a synchronous input. A parameter bit map chooses the variant per source. Asynchronous events pass through a two-flop synchronizer before they set the flag. Synchronous events set the flag on the edge that samples them and feed the request through one extra register stage. A 16-bit vector register holds the handler address that the processor jumps to. It is read and written through the same register port.

Top module: `intc_hier`

## Requirements
- R1: A source flag is set by its event even when its source, module or global enable is clear. A synchronous source's flag reads set after the first clock edge that samples the event. An asynchronous source's flag reads set after the third such edge.
- R2: `irq_o` is high only when the global enable (bit 0 at address 0x00), the module enable (bit m at address 0x01) and the source enable (bit s at 0x11+4m) are all set for some flagged source.
- R3: The vector register at address 0x02 resets to 0x0000, takes any 16-bit write, reads back through `rdata_o` and drives `ivec_o`.
- R4: The per-module identification register at 0x12+4m is 16 bits, resets to zero and reads flag AND source enable. Writes to it have no effect.
- R5: The top identification register at 0x03 has bit m set exactly when module m is enabled and has a flagged, enabled source. Bits above the module count read zero, and writes to it have no effect.
- R6: Flags, read at 0x10+4m, change from 1 to 0 only on a write of 1 to that bit at that address. Writing 0 leaves a flag alone. An event in the same cycle as its clear leaves the flag set.
- R7: While an enabled flag stays uncleared and all enables stay set, `irq_o` stays high.
- R8: When the last enabled pending source is cleared, `irq_o` falls one clock edge after the clearing edge for an asynchronous source and two edges after it for a synchronous source. The default build makes sources 0-7 of each module asynchronous and sources 8-15 synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 96 | Source events, bit 16*m+s is source s of module m |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for read and write |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |
| ivec_o | output | 16 | Interrupt vector |

## Verification
The hardest case to reach is an event landing on the same edge as a software clear of that same flag. A register write and an event pulse are independent port streams, so the bench must line them up on purpose. The bench drives both in one cycle and then reads the flag back. It also separates the two clear-to-request latencies by clearing a lone pending asynchronous source and a lone pending synchronous source. For each it samples `irq_o` after every edge that follows. The random phase mixes sparse event bursts with enable and clear writes, so flags pile up while masked at each level and show up later when the enables are opened.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_GCTL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_MODEN    = 8'h01;
  localparam logic [ADDR_W-1:0] A_IVEC     = 8'h02;
  localparam logic [ADDR_W-1:0] A_TOPID    = 8'h03;
  localparam logic [ADDR_W-1:0] A_MOD_BASE = 8'h10;

  typedef enum logic [1:0] {
    OFS_FLAG = 2'd0,
    OFS_IEN  = 2'd1,
    OFS_MID  = 2'd2,
    OFS_RSV  = 2'd3
  } mod_ofs_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/intc_module.sv
module intc_module #(
  parameter int unsigned       N_SRC     = 16,
  parameter logic [N_SRC-1:0]  ASYNC_MAP = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic             ien_we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] ien_o,
  output logic [N_SRC-1:0] mid_o,
  output logic             pend_o
);
  logic [N_SRC-1:0] flag_q, ien_q, set_ev, pend_eff, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (ASYNC_MAP[i]) begin : g_async
      intc_sync #(.W(1)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (evt_i[i]),
        .q_o   (set_ev[i])
      );
      assign pend_eff[i] = flag_q[i] & ien_q[i];
    end else begin : g_sync
      logic pdly_q;
      assign set_ev[i] = evt_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pdly_q <= 1'b0;
        else         pdly_q <= flag_q[i] & ien_q[i];
      end
      assign pend_eff[i] = pdly_q;
    end
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_mask) | set_ev;
      if (ien_we_i) ien_q <= wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign ien_o  = ien_q;
  assign mid_o  = flag_q & ien_q;
  assign pend_o = |pend_eff;

  assert_flag_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_ev) |=> ((flag_q & $past(set_ev)) == $past(set_ev)));

  assert_flag_clear_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag_q) & ~flag_q & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int unsigned N_MOD = 6,
  parameter int unsigned N_SRC = 16
) (
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         gen_i,
  input  logic [N_MOD-1:0]             moden_i,
  input  logic [DATA_W-1:0]            ivec_i,
  input  logic [N_MOD-1:0]             topid_i,
  input  logic [N_MOD-1:0][N_SRC-1:0]  flags_i,
  input  logic [N_MOD-1:0][N_SRC-1:0]  ien_i,
  input  logic [N_MOD-1:0][N_SRC-1:0]  mid_i,
  output logic                         gctl_we_o,
  output logic                         moden_we_o,
  output logic                         ivec_we_o,
  output logic [N_MOD-1:0]             clr_we_o,
  output logic [N_MOD-1:0]             ien_we_o,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  mod_ofs_e          ofs;
  logic              mod_hit;

  assign rel     = addr_i - A_MOD_BASE;
  assign idx     = rel[ADDR_W-1:2];
  assign ofs     = mod_ofs_e'(rel[1:0]);
  assign mod_hit = (addr_i >= A_MOD_BASE) && (int'(idx) < int'(N_MOD));

  assign gctl_we_o  = wr_en_i && (addr_i == A_GCTL);
  assign moden_we_o = wr_en_i && (addr_i == A_MODEN);
  assign ivec_we_o  = wr_en_i && (addr_i == A_IVEC);

  for (genvar m = 0; m < N_MOD; m++) begin : g_we
    assign clr_we_o[m] = wr_en_i && mod_hit && (int'(idx) == m) && (ofs == OFS_FLAG);
    assign ien_we_o[m] = wr_en_i && mod_hit && (int'(idx) == m) && (ofs == OFS_IEN);
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_GCTL:  rdata_o[0]         = gen_i;
      A_MODEN: rdata_o[N_MOD-1:0] = moden_i;
      A_IVEC:  rdata_o            = ivec_i;
      A_TOPID: rdata_o[N_MOD-1:0] = topid_i;
      default: begin
        for (int m = 0; m < N_MOD; m++) begin
          if (mod_hit && (int'(idx) == m)) begin
            unique case (ofs)
              OFS_FLAG: rdata_o[N_SRC-1:0] = flags_i[m];
              OFS_IEN:  rdata_o[N_SRC-1:0] = ien_i[m];
              OFS_MID:  rdata_o[N_SRC-1:0] = mid_i[m];
              default:  rdata_o            = '0;
            endcase
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/intc_hier.sv
module intc_hier
  import intc_pkg::*;
#(
  parameter int unsigned              N_MOD     = 6,
  parameter int unsigned              N_SRC     = 16,
  parameter logic [N_MOD*N_SRC-1:0]   ASYNC_MAP = {N_MOD{16'h00FF}}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_MOD*N_SRC-1:0]   evt_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     irq_o,
  output logic [DATA_W-1:0]        ivec_o
);
  logic                        gen_q, irq_q;
  logic [N_MOD-1:0]            moden_q, topid, mod_pend;
  logic [DATA_W-1:0]           ivec_q;
  logic [N_MOD-1:0][N_SRC-1:0] flags, ien, mid;
  logic                        gctl_we, moden_we, ivec_we;
  logic [N_MOD-1:0]            clr_we, ien_we;

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    intc_module #(
      .N_SRC    (N_SRC),
      .ASYNC_MAP(ASYNC_MAP[m*N_SRC +: N_SRC])
    ) u_mod (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[m*N_SRC +: N_SRC]),
      .clr_we_i(clr_we[m]),
      .ien_we_i(ien_we[m]),
      .wdata_i (wdata_i[N_SRC-1:0]),
      .flag_o  (flags[m]),
      .ien_o   (ien[m]),
      .mid_o   (mid[m]),
      .pend_o  (mod_pend[m])
    );
    assign topid[m] = moden_q[m] & (|mid[m]);
  end

  intc_decode #(.N_MOD(N_MOD), .N_SRC(N_SRC)) u_dec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .gen_i     (gen_q),
    .moden_i   (moden_q),
    .ivec_i    (ivec_q),
    .topid_i   (topid),
    .flags_i   (flags),
    .ien_i     (ien),
    .mid_i     (mid),
    .gctl_we_o (gctl_we),
    .moden_we_o(moden_we),
    .ivec_we_o (ivec_we),
    .clr_we_o  (clr_we),
    .ien_we_o  (ien_we),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q   <= 1'b0;
      moden_q <= '0;
      ivec_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (gctl_we)  gen_q   <= wdata_i[0];
      if (moden_we) moden_q <= wdata_i[N_MOD-1:0];
      if (ivec_we)  ivec_q  <= wdata_i;
      irq_q <= gen_q & (|(moden_q & mod_pend));
    end
  end

  assign irq_o  = irq_q;
  assign ivec_o = ivec_q;

  assert_irq_needs_global_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gen_q));

  assert_irq_needs_module_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(moden_q) != '0));

  assert_ivec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ivec_we |=> $stable(ivec_q));
endmodule

// File: tb/intc_hier_tb_top.sv
`timescale 1ns/1ps
module intc_hier_tb_top;
  localparam int NM = 6;
  localparam int NS = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NM*NS-1:0]  evt = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata, ivec;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_flag [NM];
  logic [15:0] m_ien  [NM];
  logic [NM-1:0] m_moden;
  logic        m_gen;

  always #2.5 clk = ~clk;

  intc_hier dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .ivec_o(ivec)
  );

  function automatic logic [7:0] maddr(int m, int ofs);
    return 8'(16 + m*4 + ofs);
  endfunction

  function automatic logic [15:0] exp_topid();
    logic [15:0] t = '0;
    for (int m = 0; m < NM; m++) t[m] = m_moden[m] && ((m_flag[m] & m_ien[m]) != 0);
    return t;
  endfunction

  function automatic logic exp_irq();
    return m_gen && (exp_topid() != 0);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulse(logic [NM*NS-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    for (int m = 0; m < NM; m++) m_flag[m] |= v[m*NS +: NS];
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(int m);
    logic [15:0] v;
    rd(8'h03, v);        chk("R5 topid", v, exp_topid());
    chk("R2 irq", {15'b0, irq}, {15'b0, exp_irq()});
    rd(maddr(m, 0), v);  chk("R1/R6 flags", v, m_flag[m]);
    rd(maddr(m, 2), v);  chk("R4 mid", v, m_flag[m] & m_ien[m]);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog timeout act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [NM*NS-1:0] ev;
    void'($urandom(32'h5eed));
    for (int m = 0; m < NM; m++) begin m_flag[m] = '0; m_ien[m] = '0; end
    m_moden = '0; m_gen = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(8'h02, v); chk("R3 ivec reset", v, 16'h0000);
    chk("R3 ivec_o reset", ivec, 16'h0000);
    rd(8'h03, v); chk("R5 topid reset", v, 16'h0000);
    for (int m = 0; m < NM; m++) begin rd(maddr(m, 2), v); chk("R4 mid reset", v, 16'h0000); end
    chk("R2 irq reset", {15'b0, irq}, 16'h0000);

    wr(8'h02, 16'hBEEF);
    rd(8'h02, v); chk("R3 ivec readback", v, 16'hBEEF);
    chk("R3 ivec_o", ivec, 16'hBEEF);

    // flag latches with everything masked (async source 3, module 2)
    ev = '0; ev[2*NS+3] = 1'b1;
    pulse(ev); settle();
    rd(maddr(2, 0), v); chk("R1 masked flag", v, 16'h0008);
    rd(maddr(2, 2), v); chk("R4 mid masked", v, 16'h0000);
    chk("R2 irq masked", {15'b0, irq}, 16'h0000);

    wr(maddr(2, 1), 16'h0208); m_ien[2] = 16'h0208;
    wr(8'h01, 16'h003F);       m_moden = 6'h3F;
    settle();
    rd(maddr(2, 2), v); chk("R4 mid enabled", v, 16'h0008);
    rd(8'h03, v);       chk("R5 topid m2", v, 16'h0004);
    chk("R2 irq global off", {15'b0, irq}, 16'h0000);
    wr(8'h00, 16'h0001); m_gen = 1'b1;
    settle();
    chk("R2 irq all enabled", {15'b0, irq}, 16'h0001);
    repeat (10) @(negedge clk);
    chk("R7 irq held", {15'b0, irq}, 16'h0001);

    // read-only registers ignore writes
    wr(maddr(2, 2), 16'hFFFF);
    rd(maddr(2, 2), v); chk("R4 mid write ignored", v, 16'h0008);
    rd(maddr(2, 0), v); chk("R4 flags after mid write", v, 16'h0008);
    wr(8'h03, 16'hFFFF);
    rd(8'h03, v);       chk("R5 topid write ignored", v, 16'h0004);

    // async clear latency: one edge
    wr(maddr(2, 0), 16'h0008); m_flag[2] = '0;
    #1 chk("R8 async edge0", {15'b0, irq}, 16'h0001);
    @(negedge clk); #1 chk("R8 async edge1", {15'b0, irq}, 16'h0000);

    // sync source 9: clear latency two edges
    ev = '0; ev[2*NS+9] = 1'b1;
    pulse(ev); settle();
    chk("R1 sync flag irq", {15'b0, irq}, 16'h0001);
    wr(maddr(2, 0), 16'h0200); m_flag[2] = '0;
    #1 chk("R8 sync edge0", {15'b0, irq}, 16'h0001);
    @(negedge clk); #1 chk("R8 sync edge1", {15'b0, irq}, 16'h0001);
    @(negedge clk); #1 chk("R8 sync edge2", {15'b0, irq}, 16'h0000);

    // writing zero does not clear; event wins over clear
    pulse(ev); settle();
    wr(maddr(2, 0), 16'h0000);
    rd(maddr(2, 0), v); chk("R6 write zero keeps", v, 16'h0200);
    @(negedge clk); wr_en = 1'b1; addr = maddr(2, 0); wdata = 16'h0200; evt = ev;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rd(maddr(2, 0), v); chk("R6 set beats clear", v, 16'h0200);

    // clean slate for random phase
    for (int m = 0; m < NM; m++) begin
      wr(maddr(m, 0), 16'hFFFF); wr(maddr(m, 1), 16'h0000);
      m_flag[m] = '0; m_ien[m] = '0;
    end
    wr(8'h01, 16'h0000); m_moden = '0;
    wr(8'h00, 16'h0000); m_gen = 1'b0;
    settle();
    chk("R6 cleared all", {15'b0, irq}, 16'h0000);

    for (int it = 0; it < 400; it++) begin
      int op;
      int m;
      logic [15:0] d;
      op = int'($urandom % 5);
      m  = int'($urandom % NM);
      d  = 16'($urandom);
      case (op)
        0: begin
          for (int k = 0; k < NM*NS; k++) ev[k] = (($urandom % 12) == 0);
          pulse(ev);
        end
        1: begin wr(maddr(m, 0), d & 16'($urandom)); m_flag[m] &= ~(d & 16'(0)) ; end
        2: begin wr(maddr(m, 1), d); m_ien[m] = d; end
        3: begin wr(8'h01, d); m_moden = d[NM-1:0]; end
        default: begin wr(8'h00, d); m_gen = d[0]; end
      endcase
      if (op == 1) begin
        // recover exact mask that was written
        m_flag[m] &= ~wdata;
      end
      settle();
      check_all(m);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule